// File: doc/BRIEF.md
# Subroutine-Call Bus Cycle Sequencer

This block runs the memory-bus cycles of a three-byte absolute subroutine call on an 8-bit processor that has a 16-bit address bus and a stack fixed in page 1. The surrounding core fetches the opcode itself. It then pulses `start` with the program counter of that opcode and the current stack pointer. The sequencer takes over the bus for five cycles. During these cycles it reads the low target byte, spends one internal cycle, pushes the return address, and reads the high target byte. At the end it hands back the new program counter and the updated stack pointer.

The high target byte is fetched only after both return-address bytes have been written. If a call's operand sits inside the stack page, the fetch therefore returns whatever the pushes just stored there. The block keeps this ordering exactly. Memory is combinational from the block's point of view: a read byte is taken on `rd_byte` at the clock edge that ends the read cycle.

Top module: `call_bus_seq`

## Requirements
- R1: After reset, `busy`, `wr_en` and `done` are 0, `new_pc` is 0x0000 and `sp_now` is 0xFF.
- R2: In the first cycle after `start` is taken while idle, `bus_addr` is the opcode PC plus 1 (16-bit wrap), `wr_en` is 0, and the byte read becomes the low half of the target.
- R3: The second cycle is internal: `bus_addr` is 0x0100 + SP and `wr_en` is 0.
- R4: The third cycle writes the high byte of (opcode PC + 2) to 0x0100 + SP with `wr_en` = 1. SP then drops by one.
- R5: The fourth cycle writes the low byte of (opcode PC + 2) to 0x0100 + the decremented SP with `wr_en` = 1. SP then drops by one again. `wr_en` is never high in any other cycle.
- R6: The fifth cycle reads the high target byte from opcode PC + 2 with `wr_en` = 0 and `done` = 1.
- R7: From the cycle after `done`, `new_pc` equals {high byte, low byte} and `sp_now` equals the starting SP minus 2, modulo 256.
- R8: When the operand address coincides with a stack slot written by a push, the high target byte is the pushed value. A low target byte is always the value held before the call.
- R9: `start` has no effect while `busy` is 1. The bus pattern and the result come from the call already running.
- R10: Address arithmetic wraps in 16 bits: an opcode at 0xFFFE reads 0xFFFF and 0x0000 and pushes 0x0000.
- R11: `done` is a single-cycle pulse, `busy` is high for exactly five cycles per call, and `busy` falls in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a call sequence (taken only when idle) |
| op_pc | input | 16 | Address of the call opcode |
| sp_in | input | 8 | Stack pointer at the start of the call |
| rd_byte | input | 8 | Read data from memory |
| bus_addr | output | 16 | Memory address for the current cycle |
| wr_byte | output | 8 | Write data |
| wr_en | output | 1 | Write enable, high only in the two push cycles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | High in the final (high-target-read) cycle |
| new_pc | output | 16 | Loaded program counter |
| sp_now | output | 8 | Current stack pointer |

## Verification
The bench goes after the stack-page overlap, placing the target high byte exactly on the slot of each push. A design that fetched both target bytes before pushing would return the stale preloaded byte and jump to the wrong address. Stack-pointer values 0x00 and 0x01 make the pushes straddle the page wrap. A design that carried the borrow into the page byte would write to page 0 or report the wrong final SP. A call at 0xFFFE catches a 17-bit or saturating PC add. Holding `start` high through a whole call, with a different PC on the input, shows whether the block restarts or picks up the new PC in mid-sequence.

// File: rtl/call_seq_pkg.sv
package call_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SP_W   = 8;
    localparam logic [ADDR_W-SP_W-1:0] STACK_PAGE = 8'h01;
    localparam logic [SP_W-1:0] SP_RESET = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TGT_LO,
        ST_GAP,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_TGT_HI
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              we;
    } bus_cycle_t;

    function automatic logic [ADDR_W-1:0] stack_slot(input logic [SP_W-1:0] sp);
        return {STACK_PAGE, sp};
    endfunction

    // Address of the final byte of the call: the pushed return value.
    function automatic logic [ADDR_W-1:0] link_addr(input logic [ADDR_W-1:0] pc);
        return pc + ADDR_W'(2);
    endfunction

endpackage

// File: rtl/call_seq_fsm.sv
module call_seq_fsm
    import call_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output seq_state_e state,
    output logic       busy,
    output logic       done
);

    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_TGT_LO;
            ST_TGT_LO:  nxt = ST_GAP;
            ST_GAP:     nxt = ST_PUSH_HI;
            ST_PUSH_HI: nxt = ST_PUSH_LO;
            ST_PUSH_LO: nxt = ST_TGT_HI;
            ST_TGT_HI:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_TGT_HI);

endmodule

// File: rtl/call_seq_regs.sv
module call_seq_regs
    import call_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic              start,
    input  logic [ADDR_W-1:0] op_pc,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] pc_q,
    output logic [SP_W-1:0]   sp_q,
    output logic [ADDR_W-1:0] new_pc
);

    logic [DATA_W-1:0] tgt_lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            sp_q     <= SP_RESET;
            tgt_lo_q <= '0;
            new_pc   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    pc_q <= op_pc;
                    sp_q <= sp_in;
                end
                ST_TGT_LO:  tgt_lo_q <= rd_byte;
                ST_PUSH_HI,
                ST_PUSH_LO: sp_q <= sp_q - SP_W'(1);
                ST_TGT_HI:  new_pc <= {rd_byte, tgt_lo_q};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/call_seq_bus.sv
module call_seq_bus
    import call_seq_pkg::*;
(
    input  seq_state_e        state,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [SP_W-1:0]   sp_q,
    output bus_cycle_t        cyc
);

    logic [ADDR_W-1:0] ret;

    assign ret = link_addr(pc_q);

    always_comb begin
        cyc = '{addr: pc_q, data: '0, we: 1'b0};
        unique case (state)
            ST_TGT_LO:  cyc.addr = pc_q + ADDR_W'(1);
            ST_GAP:     cyc.addr = stack_slot(sp_q);
            ST_PUSH_HI: cyc = '{addr: stack_slot(sp_q), data: ret[ADDR_W-1:DATA_W], we: 1'b1};
            ST_PUSH_LO: cyc = '{addr: stack_slot(sp_q), data: ret[DATA_W-1:0], we: 1'b1};
            ST_TGT_HI:  cyc.addr = ret;
            default: ;
        endcase
    end

endmodule

// File: rtl/call_bus_seq.sv
module call_bus_seq
    import call_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] op_pc,
    input  logic [7:0]  sp_in,
    input  logic [7:0]  rd_byte,
    output logic [15:0] bus_addr,
    output logic [7:0]  wr_byte,
    output logic        wr_en,
    output logic        busy,
    output logic        done,
    output logic [15:0] new_pc,
    output logic [7:0]  sp_now
);

    seq_state_e        state;
    logic [ADDR_W-1:0] pc_q;
    logic [SP_W-1:0]   sp_q;
    bus_cycle_t        cyc;

    call_seq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .state (state),
        .busy  (busy),
        .done  (done)
    );

    call_seq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .start   (start),
        .op_pc   (op_pc),
        .sp_in   (sp_in),
        .rd_byte (rd_byte),
        .pc_q    (pc_q),
        .sp_q    (sp_q),
        .new_pc  (new_pc)
    );

    call_seq_bus u_bus (
        .state (state),
        .pc_q  (pc_q),
        .sp_q  (sp_q),
        .cyc   (cyc)
    );

    assign bus_addr = cyc.addr;
    assign wr_byte  = cyc.data;
    assign wr_en    = cyc.we;
    assign sp_now   = sp_q;

endmodule

// File: rtl/call_bus_seq_chk.sv
module call_bus_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] bus_addr,
    input logic [7:0]  rd_byte,
    input logic        wr_en,
    input logic        busy,
    input logic        done,
    input logic [15:0] new_pc,
    input logic [7:0]  sp_now
);

    // R4
    write_in_stack_page_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> bus_addr[15:8] == 8'h01);

    // R5
    two_writes_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |=> !wr_en);

    // R5
    sp_drops_per_push_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> sp_now == $past(sp_now) - 8'd1);

    // R6
    no_write_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en);

    // R7
    pc_high_from_last_read_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> new_pc[15:8] == $past(rd_byte));

    // R11
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R9
    busy_holds_until_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

bind call_bus_seq call_bus_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .rd_byte  (rd_byte),
    .wr_en    (wr_en),
    .busy     (busy),
    .done     (done),
    .new_pc   (new_pc),
    .sp_now   (sp_now)
);

// File: tb/call_bus_seq_bench.sv
module call_bus_seq_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
        logic        we;
        logic        dn;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] op_pc = '0;
    logic [7:0]  sp_in = '0;
    logic [7:0]  rd_byte = '0;
    logic [15:0] bus_addr;
    logic [7:0]  wr_byte;
    logic        wr_en;
    logic        busy;
    logic        done;
    logic [15:0] new_pc;
    logic [7:0]  sp_now;

    int n_checks = 0;
    int n_fail = 0;

    exp_t        sb[$];
    logic [7:0]  mem [logic [15:0]];

    call_bus_seq u_call_bus_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op_pc    (op_pc),
        .sp_in    (sp_in),
        .rd_byte  (rd_byte),
        .bus_addr (bus_addr),
        .wr_byte  (wr_byte),
        .wr_en    (wr_en),
        .busy     (busy),
        .done     (done),
        .new_pc   (new_pc),
        .sp_now   (sp_now)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] peek(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Memory model: writes land at the clock edge, read data settles mid-cycle.
    always @(posedge clk) if (!rst && wr_en) mem[bus_addr] = wr_byte;
    always @(negedge clk) rd_byte <= peek(bus_addr);

    // Monitor: compare every busy cycle against the scoreboard.
    always @(negedge clk) begin
        if (!rst && busy) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11 unexpected busy cycle", 32'(bus_addr), 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(bus_addr == e.addr, e.tag, 32'(bus_addr), 32'(e.addr));
                check(wr_en == e.we, e.tag, 32'(wr_en), 32'(e.we));
                if (e.we) check(wr_byte == e.data, e.tag, 32'(wr_byte), 32'(e.data));
                check(done == e.dn, e.tag, 32'(done), 32'(e.dn));
            end
        end
    end

    task automatic run_call(input logic [15:0] pc, input logic [7:0] sp,
                            input bit hold, input string tag);
        logic [15:0] ret;
        logic [15:0] slot_h;
        logic [15:0] slot_l;
        logic [7:0]  lo;
        logic [7:0]  hi;
        ret    = pc + 16'd2;
        slot_h = {8'h01, sp};
        slot_l = {8'h01, sp - 8'd1};
        lo     = peek(pc + 16'd1);
        if (ret == slot_l)      hi = ret[7:0];
        else if (ret == slot_h) hi = ret[15:8];
        else                    hi = peek(ret);
        sb.push_back('{pc + 16'd1, 8'h00, 1'b0, 1'b0, {tag, " R2 low read"}});
        sb.push_back('{slot_h, 8'h00, 1'b0, 1'b0, {tag, " R3 internal"}});
        sb.push_back('{slot_h, ret[15:8], 1'b1, 1'b0, {tag, " R4 push high"}});
        sb.push_back('{slot_l, ret[7:0], 1'b1, 1'b0, {tag, " R5 push low"}});
        sb.push_back('{ret, 8'h00, 1'b0, 1'b1, {tag, " R6 high read"}});
        @(negedge clk);
        start = 1'b1; op_pc = pc; sp_in = sp;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (hold) begin op_pc = pc ^ 16'h5555; sp_in = sp ^ 8'h33; end
            else start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        #1;
        check(new_pc == {hi, lo}, {tag, " R7 new pc"}, 32'(new_pc), 32'({hi, lo}));
        check(sp_now == sp - 8'd2, {tag, " R7 final sp"}, 32'(sp_now), 32'(sp - 8'd2));
        check(!busy && sb.size() == 0, {tag, " R11 five busy cycles"}, 32'(sb.size()), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!busy && !wr_en && !done, "R1 reset controls", 32'({busy, wr_en, done}), 32'h0);
        check(new_pc == 16'h0000, "R1 reset pc", 32'(new_pc), 32'h0);
        check(sp_now == 8'hFF, "R1 reset sp", 32'(sp_now), 32'hFF);

        mem[16'h1235] = 8'h78; mem[16'h1236] = 8'h56;
        run_call(16'h1234, 8'hFD, 1'b0, "plain");

        mem[16'h2001] = 8'h11; mem[16'h2002] = 8'h22;
        run_call(16'h2000, 8'h00, 1'b0, "sp00 wrap");
        run_call(16'h2000, 8'h01, 1'b0, "sp01 wrap");

        mem[16'hFFFF] = 8'hCD; mem[16'h0000] = 8'hAB;
        run_call(16'hFFFE, 8'hC0, 1'b0, "R10 pc wrap");

        // R8: operand high byte sits on the low push slot, then on the high push slot
        mem[16'h017E] = 8'h34; mem[16'h017F] = 8'hEE;
        run_call(16'h017D, 8'h80, 1'b0, "R8 overlap low slot");
        mem[16'h017F] = 8'h9A; mem[16'h0180] = 8'hEE;
        run_call(16'h017E, 8'h80, 1'b0, "R8 overlap high slot");

        mem[16'h4001] = 8'h0F; mem[16'h4002] = 8'hF0;
        run_call(16'h4000, 8'h40, 1'b1, "R9 start held");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule